// File: doc/BRIEF.md
# Multiplexed Bus Register Interface

This block is the host-facing access unit for a small clock and timer register store. A host talks to it over one 8-bit bus that carries both addresses and data. A select line tells the block which of the two the bus holds. A write with the select line low loads an internal address latch. Every later data access, with the select line high, goes to the latched location until the host loads a new address. A read with the select line low returns the latch itself. An interrupt handler can therefore save the latch, do its own accesses and then put the latch back.

One address is reserved as a command. A data-phase read on it copies the whole hidden live area, which holds the running clock and timer values, into a window of the visible RAM in one clock edge. A data-phase write on it copies that RAM window into the live area in one edge. This write copy takes effect only when the time-set lock bit is clear.

Outside logic advances the live area through an update port. If an update arrives in the same cycle as any command strobe, the block holds it for one cycle. The snapshot therefore never mixes old and new values.

Top module: `mux_bus_regif`

## Requirements
- R1: A write strobe with `sel_data` low loads `bus_in[5:0]` into the address latch, and the upper bus bits are dropped. A read with `sel_data` low shows the latch on `bus_out` with the upper two bits zero.
- R2: The address latch keeps its value through any number of data accesses and through reads with `sel_data` low. Only an address write changes it.
- R3: With `sel_data` high, a write strobe stores `bus_in` at the latched address, and `bus_out` shows that location. This applies to every address except the command address 0, and the lock address 1 is included.
- R4: After reset the address latch, the RAM and the live area are all zero.
- R5: A data-phase read strobe while the latch holds 0 copies live entries 0..7 into RAM addresses 8..15 at that clock edge. The command location reads as 0x00.
- R6: A data-phase write strobe while the latch holds 0 and bit 0 of RAM address 1 is clear copies RAM addresses 8..15 into live entries 0..7 at that clock edge. The command address stores nothing.
- R7: The same command write with bit 0 of RAM address 1 set leaves the live area unchanged.
- R8: An update on (`upd_en`, `upd_idx`, `upd_val`) is written into the live area at the next edge. If the update coincides with a command strobe, it is written one edge later instead, and a copy-out made in that cycle holds the value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_data | input | 1 | 0: bus holds an address, 1: bus holds data |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| bus_in | input | 8 | Bus value driven by the host |
| bus_out | output | 8 | Read value (latch or RAM) |
| upd_en | input | 1 | Live-area update request from the counting logic |
| upd_idx | input | 3 | Live entry to update |
| upd_val | input | 8 | New live entry value |
| live_q | output | 64 | Live area, entry i at bits [8i+7:8i] |

## Verification
The bench builds the block with its default parameters: a 64-byte RAM, an 8-entry live window at addresses 8..15, the command at address 0 and the lock at bit 0 of address 1. With a RAM this small, the bench can load every latch value and read it back. It can also fill and read back every plain RAM location using arithmetic patterns. Because the live window is only eight entries, each copy direction and the locked case can be checked entry by entry. The bench also times a coinciding update exactly against a copy-out.

// File: rtl/mux_bus_regif.sv
module mux_bus_regif #(
  parameter int DW        = 8,
  parameter int DEPTH     = 64,
  parameter int LIVE_N    = 8,
  parameter int WIN_BASE  = 8,
  parameter int CMD_ADDR  = 0,
  parameter int LOCK_ADDR = 1,
  parameter int LOCK_BIT  = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_data,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic [DW-1:0]        bus_in,
  output logic [DW-1:0]        bus_out,
  input  logic                 upd_en,
  input  logic [$clog2(LIVE_N)-1:0] upd_idx,
  input  logic [DW-1:0]        upd_val,
  output logic [LIVE_N*DW-1:0] live_q
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(LIVE_N);

  logic [DW-1:0] ram  [DEPTH];
  logic [DW-1:0] live [LIVE_N];
  logic [AW-1:0] addr_q;
  logic          pend_v;
  logic [IW-1:0] pend_idx;
  logic [DW-1:0] pend_val;

  wire is_cmd    = addr_q == AW'(CMD_ADDR);
  wire cmd_rd    = rd_stb & sel_data & is_cmd;
  wire cmd_wr    = wr_stb & sel_data & is_cmd;
  wire cmd_any   = cmd_rd | cmd_wr;
  wire locked    = ram[LOCK_ADDR][LOCK_BIT];
  wire load_live = cmd_wr & ~locked;

  assign bus_out = !sel_data ? {{(DW-AW){1'b0}}, addr_q}
                 : (is_cmd ? '0 : ram[addr_q]);

  genvar g;
  generate
    for (g = 0; g < LIVE_N; g++) begin : g_pack
      assign live_q[g*DW +: DW] = live[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (wr_stb && !sel_data) addr_q <= bus_in[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
    end else begin
      if (wr_stb && sel_data && !is_cmd) ram[addr_q] <= bus_in;
      if (cmd_rd)
        for (int j = 0; j < LIVE_N; j++) ram[WIN_BASE+j] <= live[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < LIVE_N; j++) live[j] <= '0;
      pend_v   <= 1'b0;
      pend_idx <= '0;
      pend_val <= '0;
    end else if (cmd_any) begin
      if (load_live)
        for (int j = 0; j < LIVE_N; j++) live[j] <= ram[WIN_BASE+j];
      if (upd_en) begin
        pend_v   <= 1'b1;
        pend_idx <= upd_idx;
        pend_val <= upd_val;
      end
    end else begin
      if (pend_v) live[pend_idx] <= pend_val;
      pend_v <= 1'b0;
      if (upd_en) live[upd_idx] <= upd_val;
    end
  end

  assert_addr_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !sel_data) |=> addr_q == $past(bus_in[AW-1:0]));
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && !sel_data) |=> $stable(addr_q));
  assert_copy_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |=> ram[WIN_BASE] == $past(live[0]));
  assert_copy_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_live |=> live[LIVE_N-1] == $past(ram[WIN_BASE+LIVE_N-1]));
  assert_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && locked) |=> $stable(live_q));
  assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_any && upd_en) |=> pend_v);
endmodule

// File: tb/mux_bus_regif_tb_top.sv
module mux_bus_regif_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       sel_data = 0, rd_stb = 0, wr_stb = 0, upd_en = 0;
  logic [7:0] bus_in = 0, upd_val = 0;
  logic [2:0] upd_idx = 0;
  logic [7:0] bus_out;
  logic [63:0] live_q;
  int vecs = 0, errs = 0;

  always #2.5 clk = ~clk;

  mux_bus_regif dut_i (.clk(clk), .rst_n(rst_n), .sel_data(sel_data), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .bus_in(bus_in), .bus_out(bus_out), .upd_en(upd_en),
    .upd_idx(upd_idx), .upd_val(upd_val), .live_q(live_q));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic s, input logic w, input logic [7:0] d);
    @(negedge clk);
    sel_data = s; bus_in = d; wr_stb = w; rd_stb = ~w;
    @(negedge clk);
    wr_stb = 0; rd_stb = 0;
  endtask

  task automatic rd_chk(string req, input logic s, input logic [7:0] exp);
    @(negedge clk);
    sel_data = s;
    #1 chk(req, {56'd0, bus_out}, {56'd0, exp});
  endtask

  task automatic upd(input logic [2:0] i, input logic [7:0] v);
    @(negedge clk);
    upd_en = 1; upd_idx = i; upd_val = v;
    @(negedge clk);
    upd_en = 0;
  endtask

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R4 reset state
    rd_chk("R4 latch", 0, 8'h00);
    chk("R4 live", live_q, 64'd0);
    rd_chk("R4 ram0", 1, 8'h00);
    // R1 every latch value, upper bits dropped
    for (int a = 0; a < 64; a++) begin
      acc(0, 1, 8'(a) | 8'hC0);
      rd_chk("R1 latch", 0, 8'(a));
    end
    // R3 plain RAM sweep
    for (int a = 1; a < 64; a++) begin
      acc(0, 1, 8'(a));
      acc(1, 1, pat(a));
    end
    for (int a = 1; a < 64; a++) begin
      acc(0, 1, 8'(a));
      rd_chk("R3 ram", 1, pat(a));
    end
    // R2 latch persists across data accesses
    acc(0, 1, 8'd20);
    acc(1, 1, 8'h5A);
    acc(1, 0, 8'h00);
    acc(0, 0, 8'h00);
    rd_chk("R2 latch", 0, 8'd20);
    rd_chk("R2 data", 1, 8'h5A);
    // R8 plain update
    for (int i = 0; i < 8; i++) upd(3'(i), 8'(i * 17 + 3));
    for (int i = 0; i < 8; i++) chk("R8 upd", 64'(live_q[i*8 +: 8]), 64'(i * 17 + 3));
    // R5 copy out
    acc(0, 1, 8'd0);
    acc(1, 0, 8'h00);
    rd_chk("R5 cmd reads zero", 1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      acc(0, 1, 8'(8 + i));
      rd_chk("R5 window", 1, 8'(i * 17 + 3));
    end
    // R6 copy in, lock clear
    acc(0, 1, 8'd1); acc(1, 1, 8'h00);
    for (int i = 0; i < 8; i++) begin
      acc(0, 1, 8'(8 + i)); acc(1, 1, 8'(8'hA0 + i));
    end
    acc(0, 1, 8'd0); acc(1, 1, 8'hEE);
    for (int i = 0; i < 8; i++) chk("R6 live", 64'(live_q[i*8 +: 8]), 64'(8'hA0 + i));
    rd_chk("R6 cmd not stored", 1, 8'h00);
    // R7 locked copy in
    acc(0, 1, 8'd1); acc(1, 1, 8'h01);
    for (int i = 0; i < 8; i++) begin
      acc(0, 1, 8'(8 + i)); acc(1, 1, 8'(8'h30 + i));
    end
    snap = live_q;
    acc(0, 1, 8'd0); acc(1, 1, 8'h00);
    repeat (2) @(negedge clk);
    chk("R7 live unchanged", live_q, snap);
    // R8 update coincident with copy out is deferred
    @(negedge clk);
    sel_data = 1; rd_stb = 1; upd_en = 1; upd_idx = 3'd2; upd_val = 8'h99;
    @(negedge clk);
    rd_stb = 0; upd_en = 0;
    chk("R8 deferred", 64'(live_q[16 +: 8]), 64'(8'hA2));
    @(negedge clk);
    chk("R8 applied", 64'(live_q[16 +: 8]), 64'h99);
    acc(0, 1, 8'd10);
    rd_chk("R8 snapshot old", 1, 8'hA2);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule